// File: doc/BRIEF.md
# Serial Divider Configuration Port for a Clock Synthesizer

This block sits beside the PLL of a clock synthesizer and holds the divider settings that the analog side uses: a 9-bit feedback divide value, a 2-bit output divide select, two spread-direction flags and a 6-bit spread amount. It accepts these settings over a write-only two-wire serial bus (I2C protocol, slave role) or from a set of parallel pins. Both bus lines are oversampled by the system clock through two-flop synchronizers, and the block drives only an open-drain pull-down enable on the data line.

A bus write is the address byte followed by exactly four data bytes. The first data byte is a placeholder and is dropped. The next three fill a shadow copy of the settings. The shadow copy moves into the live settings only when a STOP ends a transfer that carried all four data bytes. A transfer that stops early changes nothing. Bytes past the fourth get no acknowledge.

A parallel-load control input (active low) overrides the bus. While it is low the divider outputs follow the pins and spread is switched off. When it returns high the last pin values stay until a completed bus write replaces them.

Top module: `synth_cfg_i2c`

## Requirements
- R1: After reset, `fb_div` = 256, `out_sel` = 0, `spread_up` = `spread_dn` = 0, `spread_amt` = 0 and `sda_pull` = 0.
- R2: The slave answers the address byte {1,1,0,1,1,`addr_sel`,0} followed by a write bit 0 (MSB first). It acknowledges by pulling the data line low during the ninth clock pulse.
- R3: An address byte with another address, or with the read bit set to 1, gets no acknowledge. The rest of that transfer gets no acknowledge and changes no output.
- R4: `sda_pull` is asserted only while SCL is low after the eighth bit of an accepted byte. It stays on through the ninth high phase and is off again by the end of the next low phase. It is never on while a data bit is high.
- R5: Payload layout. Data byte 0 is discarded. Data byte 1: bits [7:6] are the output select and bits [5:0] are divide bits 8..3. Data byte 2: bits [7:5] are divide bits 2..0 and bits [4:0] are ignored. Data byte 3: bit 7 is spread-up, bit 6 is spread-down and bits [5:0] are the spread amount.
- R6: Data bytes after the fourth get no acknowledge and do not alter the values committed by that transfer.
- R7: Settings change only on a STOP that follows four acknowledged data bytes. A STOP after fewer data bytes leaves all outputs unchanged.
- R8: While `pload_n` is 0, `fb_div` and `out_sel` follow `pin_div` and `pin_sel`, and `spread_up` and `spread_dn` read 0.
- R9: After `pload_n` rises, the pin values are held against later pin changes until `pload_n` falls again or a completed bus write replaces them. The stored spread flags reappear.
- R10: A bus write that completes while `pload_n` is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| addr_sel | input | 1 | Selects address bit 1 |
| pload_n | input | 1 | 0: parallel pins drive the dividers |
| pin_div | input | 9 | Parallel feedback divide value |
| pin_sel | input | 2 | Parallel output divide select |
| fb_div | output | 9 | Active feedback divide value |
| out_sel | output | 2 | Active output divide select |
| spread_up | output | 1 | Active spread-up flag |
| spread_dn | output | 1 | Active spread-down flag |
| spread_amt | output | 6 | Active spread amount |

## Verification
The case hardest to reach from the ports is a transfer that the slave must refuse partway through: a fifth and sixth byte after a full payload, or a STOP after only three data bytes. Neither may leak into the live settings. The bench drives these cases with a bit-level bus master whose data line is wired-AND with `sda_pull`. It reads the acknowledge of every byte and compares the outputs with values it computes from the byte fields. It also sweeps all 256 address byte values for both `addr_sel` settings, so that every neighbour of the two valid addresses and every read request must get a NACK.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  parameter int DIV_W    = 9;
  parameter int SEL_W    = 2;
  parameter int AMT_W    = 6;
  parameter int DATA_BYTES = 4;
  parameter int DIV_RST  = 256;
  parameter logic [6:0] ADDR_BASE = 7'b1101100;
  localparam int CNT_W   = $clog2(DATA_BYTES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_ACK, ST_FULL
  } bus_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] line_in;
  logic [1:0] line_prev;
  logic [STAGES-1:0] ff [2];

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        ff[g]        <= '1;
        line_prev[g] <= 1'b1;
      end else begin
        ff[g]        <= {ff[g][STAGES-2:0], line_in[g]};
        line_prev[g] <= ff[g][STAGES-1];
      end
    end
  end

  assign scl_s     = ff[0][STAGES-1];
  assign sda_s     = ff[1][STAGES-1];
  assign scl_rise  = scl_s & ~line_prev[0];
  assign scl_fall  = ~scl_s & line_prev[0];
  assign bus_start = scl_s & line_prev[0] & line_prev[1] & ~sda_s;
  assign bus_stop  = scl_s & line_prev[0] & ~line_prev[1] & sda_s;
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       addr_sel,
  output logic       sda_pull,
  output logic       byte_we,
  output logic [1:0] byte_idx,
  output logic [7:0] byte_data,
  output logic       commit
);
  bus_st_t          st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] nbytes;
  logic             ack_hi;
  logic [7:0]       my_addr;

  assign my_addr = {ADDR_BASE[6:2], addr_sel, ADDR_BASE[0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      nbytes    <= '0;
      ack_hi    <= 1'b0;
      sda_pull  <= 1'b0;
      byte_we   <= 1'b0;
      byte_idx  <= '0;
      byte_data <= '0;
      commit    <= 1'b0;
    end else begin
      byte_we <= 1'b0;
      commit  <= 1'b0;
      if (bus_start) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        nbytes   <= '0;
        sda_pull <= 1'b0;
      end else if (bus_stop) begin
        if (st == ST_FULL) commit <= 1'b1;
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              ack_hi <= 1'b0;
              if (st == ST_ADDR) begin
                if (shreg == my_addr) begin
                  sda_pull <= 1'b1;
                  st       <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_pull  <= 1'b1;
                byte_we   <= 1'b1;
                byte_idx  <= nbytes[1:0];
                byte_data <= shreg;
                nbytes    <= nbytes + 1'b1;
                st        <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise) begin
              ack_hi <= 1'b1;
            end else if (scl_fall && ack_hi) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              st       <= (nbytes == CNT_W'(DATA_BYTES)) ? ST_FULL : ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import synth_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_we,
  input  logic [1:0]       byte_idx,
  input  logic [7:0]       byte_data,
  input  logic             commit,
  input  logic             pload_n,
  input  logic [DIV_W-1:0] pin_div,
  input  logic [SEL_W-1:0] pin_sel,
  output logic [DIV_W-1:0] fb_div,
  output logic [SEL_W-1:0] out_sel,
  output logic             spread_up,
  output logic             spread_dn,
  output logic [AMT_W-1:0] spread_amt
);
  logic [DIV_W-1:0] sh_div;
  logic [SEL_W-1:0] sh_sel;
  logic             sh_up, sh_dn, st_up, st_dn;
  logic [AMT_W-1:0] sh_amt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div <= DIV_W'(DIV_RST);
      sh_sel <= '0;
      sh_up  <= 1'b0;
      sh_dn  <= 1'b0;
      sh_amt <= '0;
    end else if (byte_we) begin
      case (byte_idx)
        2'd1: begin
          sh_sel        <= byte_data[7:6];
          sh_div[8:3]   <= byte_data[5:0];
        end
        2'd2: sh_div[2:0] <= byte_data[7:5];
        2'd3: begin
          sh_up  <= byte_data[7];
          sh_dn  <= byte_data[6];
          sh_amt <= byte_data[5:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_div     <= DIV_W'(DIV_RST);
      out_sel    <= '0;
      st_up      <= 1'b0;
      st_dn      <= 1'b0;
      spread_amt <= '0;
      spread_up  <= 1'b0;
      spread_dn  <= 1'b0;
    end else begin
      if (!pload_n) begin
        fb_div  <= pin_div;
        out_sel <= pin_sel;
      end else if (commit) begin
        fb_div     <= sh_div;
        out_sel    <= sh_sel;
        st_up      <= sh_up;
        st_dn      <= sh_dn;
        spread_amt <= sh_amt;
      end
      spread_up <= pload_n & st_up;
      spread_dn <= pload_n & st_dn;
    end
  end
endmodule

// File: rtl/synth_cfg_i2c.sv
module synth_cfg_i2c
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull,
  input  logic             addr_sel,
  input  logic             pload_n,
  input  logic [DIV_W-1:0] pin_div,
  input  logic [SEL_W-1:0] pin_sel,
  output logic [DIV_W-1:0] fb_div,
  output logic [SEL_W-1:0] out_sel,
  output logic             spread_up,
  output logic             spread_dn,
  output logic [AMT_W-1:0] spread_amt
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic byte_we, commit;
  logic [1:0] byte_idx;
  logic [7:0] byte_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_wr_slave u_slave (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .byte_we(byte_we),
    .byte_idx(byte_idx), .byte_data(byte_data), .commit(commit)
  );

  cfg_reg_bank u_bank (
    .clk(clk), .rst(rst), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_data(byte_data), .commit(commit), .pload_n(pload_n),
    .pin_div(pin_div), .pin_sel(pin_sel), .fb_div(fb_div),
    .out_sel(out_sel), .spread_up(spread_up), .spread_dn(spread_dn),
    .spread_amt(spread_amt)
  );
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pload_n,
  input logic [DIV_W-1:0] pin_div,
  input logic [SEL_W-1:0] pin_sel,
  input logic [DIV_W-1:0] fb_div,
  input logic [SEL_W-1:0] out_sel,
  input logic             spread_up,
  input logic             spread_dn,
  input logic             sda_pull,
  input logic             scl_s,
  input logic             commit
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(pload_n) && !$past(rst)) |-> (fb_div == $past(pin_div) && out_sel == $past(pin_sel))); // R8
  AST_SPREAD_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(pload_n) |-> (!spread_up && !spread_dn)); // R8
  AST_HOLD_DIV: assert property (@(posedge clk) disable iff (rst)
    ($past(pload_n) && !$past(commit)) |-> $stable(fb_div)); // R9
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s); // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R7
endmodule

bind synth_cfg_i2c synth_cfg_chk u_chk (
  .clk(clk), .rst(rst), .pload_n(pload_n), .pin_div(pin_div), .pin_sel(pin_sel),
  .fb_div(fb_div), .out_sel(out_sel), .spread_up(spread_up), .spread_dn(spread_dn),
  .sda_pull(sda_pull), .scl_s(scl_s), .commit(commit)
);

// File: tb/synth_cfg_i2c_tb.sv
`timescale 1ns/1ps
module synth_cfg_i2c_tb;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, pload_n = 1'b1;
  logic [8:0] pin_div = '0;
  logic [1:0] pin_sel = '0;
  logic sda_pull, spread_up, spread_dn;
  logic [8:0] fb_div;
  logic [1:0] out_sel;
  logic [5:0] spread_amt;
  wire sda_line = sda_m & ~sda_pull;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  bit oe_bad;
  logic [7:0] dq [6];
  logic acks [7];

  always #2.5 clk = ~clk;

  synth_cfg_i2c u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .addr_sel(addr_sel), .pload_n(pload_n), .pin_div(pin_div), .pin_sel(pin_sel),
    .fb_div(fb_div), .out_sel(out_sel), .spread_up(spread_up), .spread_dn(spread_dn),
    .spread_amt(spread_amt)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [8:0] m, input logic [1:0] n,
                         input logic u, input logic d, input logic [5:0] s);
    logic [19:0] a, e;
    a = {fb_div, out_sel, spread_up, spread_dn, spread_amt};
    e = {m, n, u, d, s};
    chk(a == e, req, 32'(a), 32'(e));
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wcyc(H);
    scl_m = 1'b1; wcyc(H/2);
    if (sda_pull) oe_bad = 1'b1;
    wcyc(H/2); scl_m = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    sda_m = 1'b1; wcyc(H);
    scl_m = 1'b1; wcyc(H/2);
    ack = ~sda_line;
    wcyc(H/2); scl_m = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] ab, input int n);
    oe_bad = 1'b0;
    sda_m = 1'b1; scl_m = 1'b1; wcyc(H);
    sda_m = 1'b0; wcyc(H);
    scl_m = 1'b0;
    byte_out(ab, acks[0]);
    for (int i = 0; i < n; i++) byte_out(dq[i], acks[i+1]);
    sda_m = 1'b0; wcyc(H);
    if (sda_pull) oe_bad = 1'b1;
    scl_m = 1'b1; wcyc(H);
    sda_m = 1'b1; wcyc(H);
    wcyc(10);
  endtask

  task automatic load(input logic [7:0] b0, input logic [8:0] m, input logic [1:0] n,
                      input logic [4:0] junk, input logic u, input logic d, input logic [5:0] s);
    dq[0] = b0;
    dq[1] = {n, m[8:3]};
    dq[2] = {m[2:0], junk};
    dq[3] = {u, d, s};
  endtask

  initial begin
    wcyc(5);
    rst = 1'b0;
    wcyc(3);
    // R1 reset values
    chk_out("R1", 9'd256, 2'd0, 1'b0, 1'b0, 6'd0);
    chk(sda_pull == 1'b0, "R1", 32'(sda_pull), 0);

    // R2 / R3 address sweep, both address selects
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int v = 0; v < 256; v++) begin
        logic exp_ack;
        exp_ack = (v[7:1] == {5'b11011, sel[0], 1'b0}) && !v[0];
        xfer(v[7:0], 0);
        chk(acks[0] == exp_ack, exp_ack ? "R2" : "R3", 32'(acks[0]), 32'(exp_ack));
        chk(!oe_bad, "R4", 32'(oe_bad), 0);
      end
    end
    chk_out("R3", 9'd256, 2'd0, 1'b0, 1'b0, 6'd0);

    // R5 / R7 full write, addr_sel 0, dummy byte differs
    addr_sel = 1'b0;
    load(8'hFF, 9'h0A5, 2'd2, 5'h1F, 1'b1, 1'b0, 6'h15);
    xfer(8'hD8, 4);
    chk(acks[1] & acks[2] & acks[3] & acks[4], "R5", 32'({acks[1],acks[2],acks[3],acks[4]}), 32'hF);
    chk(!oe_bad, "R4", 32'(oe_bad), 0);
    chk_out("R5", 9'h0A5, 2'd2, 1'b1, 1'b0, 6'h15);

    // R3 wrong address with full payload: nothing acked or changed
    load(8'h00, 9'd300, 2'd1, 5'h0, 1'b0, 1'b1, 6'h3);
    xfer(8'hDA, 4);
    chk(!(acks[0] | acks[1] | acks[4]), "R3", 32'({acks[0],acks[1],acks[4]}), 0);
    chk_out("R3", 9'h0A5, 2'd2, 1'b1, 1'b0, 6'h15);
    // R3 read bit set
    xfer(8'hD9, 4);
    chk_out("R3", 9'h0A5, 2'd2, 1'b1, 1'b0, 6'h15);

    // R7 partial transfer discarded
    xfer(8'hD8, 3);
    chk(acks[3], "R7", 32'(acks[3]), 1);
    chk_out("R7", 9'h0A5, 2'd2, 1'b1, 1'b0, 6'h15);

    // R6 extra bytes get NACK and do not change the commit
    load(8'h55, 9'd123, 2'd1, 5'h0A, 1'b0, 1'b1, 6'h2A);
    dq[4] = 8'h00; dq[5] = 8'hFF;
    xfer(8'hD8, 6);
    chk(acks[4] && !acks[5] && !acks[6], "R6", 32'({acks[4],acks[5],acks[6]}), 32'h4);
    chk(!oe_bad, "R4", 32'(oe_bad), 0);
    chk_out("R6", 9'd123, 2'd1, 1'b0, 1'b1, 6'h2A);

    // R5 second pattern, addr_sel 1, extremes
    addr_sel = 1'b1;
    load(8'h00, 9'd336, 2'd3, 5'h00, 1'b1, 1'b1, 6'h3F);
    xfer(8'hDC, 4);
    chk_out("R5", 9'd336, 2'd3, 1'b1, 1'b1, 6'h3F);
    load(8'hA5, 9'd1, 2'd0, 5'h15, 1'b0, 1'b0, 6'h01);
    xfer(8'hDC, 4);
    chk_out("R5", 9'd1, 2'd0, 1'b0, 1'b0, 6'h01);
    load(8'h00, 9'd336, 2'd3, 5'h00, 1'b1, 1'b1, 6'h3F);
    xfer(8'hDC, 4);

    // R8 parallel follow, spread forced off
    pin_div = 9'd120; pin_sel = 2'd1;
    pload_n = 1'b0; wcyc(3);
    chk_out("R8", 9'd120, 2'd1, 1'b0, 1'b0, 6'h3F);
    pin_div = 9'd200; pin_sel = 2'd2; wcyc(2);
    chk_out("R8", 9'd200, 2'd2, 1'b0, 1'b0, 6'h3F);

    // R10 bus write while parallel low ignored
    load(8'h00, 9'd150, 2'd0, 5'h0, 1'b0, 1'b0, 6'h05);
    xfer(8'hDC, 4);
    chk_out("R10", 9'd200, 2'd2, 1'b0, 1'b0, 6'h3F);

    // R9 hold after rising edge
    pload_n = 1'b1; wcyc(3);
    pin_div = 9'd77; pin_sel = 2'd3; wcyc(3);
    chk_out("R9", 9'd200, 2'd2, 1'b1, 1'b1, 6'h3F);
    // R9 completed bus write replaces held values
    load(8'h00, 9'd250, 2'd1, 5'h0, 1'b1, 1'b0, 6'h07);
    xfer(8'hDC, 4);
    chk_out("R9", 9'd250, 2'd1, 1'b1, 1'b0, 6'h07);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule